// File: doc/BRIEF.md
# DRAM Refresh Sequencer

This block keeps an asynchronous DRAM array refreshed. A free-running timer counts clock cycles up to a set refresh interval. Each time the interval expires, the block raises a refresh request toward the memory arbiter. When the arbiter grants the request, the block drives the row and column strobes (active low) through one complete refresh. It then holds both strobes high for the precharge time before it will accept another grant.

Three refresh protocols can be selected when the grant is given:

- **Row-addressed refresh:** the block supplies the row number from its own wrapping counter, with only the row strobe asserted.
- **Column-first refresh:** the column strobe falls before the row strobe, and the DRAM's internal counter selects the row.
- **Hidden refresh:** the column strobe is held low after a read, so the read data stays valid, while the row strobe is cycled a set number of times.

Normal read and write sequencing is handled elsewhere. In hidden mode the arbiter is expected to grant at the end of a read.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, and immediately after it is released, `ras_n` and `cas_n` are 1, `busy` is 0, `ref_req` is 0 and `row_addr` is 0.
- R2: The interval timer runs freely from reset and never pauses. A new refresh becomes due after every `INTERVAL` clock edges, and `ref_req` is 1 from the cycle that follows the edge on which it became due.
- R3: At most one refresh can be pending. An interval that expires while `ref_req` is already 1 is lost. `ref_req` stays 1 until a refresh starts, and it clears on the start edge unless a new interval expires on that same edge.
- R4: A refresh starts only on an edge where the sequencer is idle, `ref_req` is 1 and `ref_gnt` is 1. A grant given during an active refresh, during precharge, or while `ref_req` is 0 has no effect.
- R5: `mode_sel` value 0, and value 3, select row-addressed refresh. From the cycle after the start, `ras_n` is 0 for `T_RAS` cycles while `cas_n` stays 1.
- R6: `mode_sel` value 1 selects column-first refresh. `cas_n` is 0 alone for `CAS_LEAD` cycles. Then `ras_n` and `cas_n` are both 0 for `T_RAS` cycles.
- R7: `mode_sel` value 2 selects hidden refresh. `cas_n` is 0 for the whole active part. The sequence `ras_n` = 1 for `T_RP` cycles followed by `ras_n` = 0 for `T_RAS` cycles is repeated `HID_BURST` times.
- R8: Every refresh ends with `T_RP` cycles in which `ras_n` and `cas_n` are both 1 and `busy` is 0. `busy` is 1 in exactly the active cycles of a refresh.
- R9: `row_addr` advances by one, wrapping from 2^`ROW_W`-1 to 0, on the edge that ends the row-strobe phase of a row-addressed refresh. Column-first and hidden refreshes leave it unchanged.
- R10: The protocol is taken from `mode_sel` on the start edge. Changes to `mode_sel` after that edge do not affect the refresh in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Protocol select: 0 or 3 row-addressed, 1 column-first, 2 hidden |
| ref_gnt | input | 1 | Grant from the memory arbiter |
| ref_req | output | 1 | A refresh is pending |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_W | Row number for row-addressed refresh |
| busy | output | 1 | Refresh strobes are active |

## Verification
A phase counter that is off by one appears in the very next refresh as a strobe pulse one cycle too long or too short. An error in the burst count stretches or truncates the hidden sequence within `T_RP`+`T_RAS` cycles. An error in the pending flag shows as `ref_req` disagreeing with the interval schedule within one interval, or as a refresh that starts without a matching request. A row counter that steps on the wrong protocol shows up on `row_addr` at the end of the first column-first or hidden refresh.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    RF_RAS_ONLY = 2'd0,
    RF_CBR      = 2'd1,
    RF_HIDDEN   = 2'd2,
    RF_ALT      = 2'd3
  } rf_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LEAD = 3'd1,
    PH_GAP  = 3'd2,
    PH_ACT  = 3'd3,
    PH_PRE  = 3'd4
  } rf_phase_e;

  // Select code 3 falls back to row-addressed refresh.
  function automatic rf_mode_e resolve_mode(input logic [1:0] sel);
    return (sel == 2'd3) ? RF_RAS_ONLY : rf_mode_e'(sel);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned INTERVAL = 3120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic pending
);
  localparam int unsigned CNT_W = $clog2(INTERVAL + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  assign expire = (cnt_q == CNT_W'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      cnt_q   <= expire ? '0 : cnt_q + 1'b1;
      pending <= expire | (pending & ~take);
    end
  end
endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
  parameter int unsigned ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  function automatic logic [ROW_W-1:0] row_after(input logic [ROW_W-1:0] r);
    return r + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= row_after(row);
  end
endmodule

// File: rtl/rfsh_phase_fsm.sv
module rfsh_phase_fsm
  import rfsh_pkg::*;
#(
  parameter int unsigned T_RAS     = 4,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned CAS_LEAD  = 1,
  parameter int unsigned HID_BURST = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pending,
  input  logic       gnt,
  input  logic [1:0] mode_sel,
  output logic       start,
  output logic       row_done,
  output rf_mode_e   act_mode,
  output logic       ras_n,
  output logic       cas_n,
  output logic       busy
);
  localparam int unsigned PH_W = $clog2(max3(T_RAS, T_RP, CAS_LEAD) + 1);
  localparam int unsigned BU_W = $clog2(HID_BURST + 1);

  rf_phase_e        st_q;
  rf_mode_e         mode_q;
  logic [PH_W-1:0]  ph_q;
  logic [BU_W-1:0]  burst_q;
  logic             ph_last;

  assign ph_last  = (ph_q == '0);
  assign start    = (st_q == PH_IDLE) && pending && gnt;
  assign row_done = (st_q == PH_ACT) && ph_last && (mode_q == RF_RAS_ONLY);
  assign act_mode = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PH_IDLE;
      mode_q  <= RF_RAS_ONLY;
      ph_q    <= '0;
      burst_q <= '0;
    end else begin
      unique case (st_q)
        PH_IDLE: if (start) begin
          mode_q <= resolve_mode(mode_sel);
          unique case (resolve_mode(mode_sel))
            RF_CBR: begin
              st_q <= PH_LEAD;
              ph_q <= PH_W'(CAS_LEAD - 1);
            end
            RF_HIDDEN: begin
              st_q    <= PH_GAP;
              ph_q    <= PH_W'(T_RP - 1);
              burst_q <= BU_W'(HID_BURST - 1);
            end
            default: begin
              st_q <= PH_ACT;
              ph_q <= PH_W'(T_RAS - 1);
            end
          endcase
        end
        PH_LEAD, PH_GAP: begin
          if (ph_last) begin
            st_q <= PH_ACT;
            ph_q <= PH_W'(T_RAS - 1);
          end else ph_q <= ph_q - 1'b1;
        end
        PH_ACT: begin
          if (ph_last) begin
            ph_q <= PH_W'(T_RP - 1);
            if (mode_q == RF_HIDDEN && burst_q != '0) begin
              st_q    <= PH_GAP;
              burst_q <= burst_q - 1'b1;
            end else st_q <= PH_PRE;
          end else ph_q <= ph_q - 1'b1;
        end
        PH_PRE: begin
          if (ph_last) st_q <= PH_IDLE;
          else         ph_q <= ph_q - 1'b1;
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ras_n = 1'b1;
    cas_n = 1'b1;
    busy  = 1'b0;
    unique case (st_q)
      PH_LEAD: begin cas_n = 1'b0; busy = 1'b1; end
      PH_GAP:  begin cas_n = 1'b0; busy = 1'b1; end
      PH_ACT:  begin
        ras_n = 1'b0;
        cas_n = (mode_q == RF_RAS_ONLY);
        busy  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import rfsh_pkg::*;
#(
  parameter int unsigned INTERVAL  = 3120,
  parameter int unsigned T_RAS     = 4,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned CAS_LEAD  = 1,
  parameter int unsigned HID_BURST = 2,
  parameter int unsigned ROW_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] row_addr,
  output logic             busy
);
  logic     seq_start;
  logic     seq_row_done;
  rf_mode_e seq_mode;

  rfsh_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (seq_start),
    .pending (ref_req)
  );

  rfsh_phase_fsm #(
    .T_RAS(T_RAS), .T_RP(T_RP), .CAS_LEAD(CAS_LEAD), .HID_BURST(HID_BURST)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pending  (ref_req),
    .gnt      (ref_gnt),
    .mode_sel (mode_sel),
    .start    (seq_start),
    .row_done (seq_row_done),
    .act_mode (seq_mode),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .busy     (busy)
  );

  rfsh_row_counter #(.ROW_W(ROW_W)) u_rows (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (seq_row_done),
    .row   (row_addr)
  );
endmodule

// File: rtl/rfsh_checker.sv
module rfsh_checker
  import rfsh_pkg::*;
#(
  parameter int unsigned ROW_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_req,
  input logic             ref_gnt,
  input logic             ras_n,
  input logic             cas_n,
  input logic             busy,
  input logic [ROW_W-1:0] row_addr,
  input logic             start,
  input rf_mode_e         act_mode
);
  assert_start_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ref_req && ref_gnt));

  assert_pending_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !start) |=> ref_req);

  assert_rasonly_cas_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == RF_RAS_ONLY && !ras_n) |-> cas_n);

  assert_cas_leads_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  assert_precharge_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_n && cas_n));

  assert_row_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (row_addr != $past(row_addr)) |-> (row_addr == ROW_W'($past(row_addr) + 1'b1)));

  assert_row_only_rasonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (row_addr != $past(row_addr)) |-> ($past(act_mode) == RF_RAS_ONLY && $rose(ras_n)));
endmodule

bind dram_refresh_seq rfsh_checker #(.ROW_W(ROW_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_req  (ref_req),
  .ref_gnt  (ref_gnt),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .busy     (busy),
  .row_addr (row_addr),
  .start    (seq_start),
  .act_mode (seq_mode)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int INTERVAL  = 24;
  localparam int T_RAS     = 4;
  localparam int T_RP      = 3;
  localparam int CAS_LEAD  = 1;
  localparam int HID_BURST = 2;
  localparam int ROW_W     = 8;
  localparam int WD_LIMIT  = 60000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode_sel = 2'd0;
  logic             ref_gnt = 1'b0;
  logic             ref_req, ras_n, cas_n, busy;
  logic [ROW_W-1:0] row_addr;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .INTERVAL(INTERVAL), .T_RAS(T_RAS), .T_RP(T_RP), .CAS_LEAD(CAS_LEAD),
    .HID_BURST(HID_BURST), .ROW_W(ROW_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Reference model: each queued entry is one expected output cycle.
  typedef struct { bit ras; bit cas; bit bsy; bit inc; } slot_t;
  slot_t plan[$];
  int    m_cnt  = 0;
  bit    m_pend = 0;
  int    m_row  = 0;

  function automatic slot_t mk(bit r, bit c, bit b, bit i);
    slot_t s;
    s.ras = r; s.cas = c; s.bsy = b; s.inc = i;
    return s;
  endfunction

  task automatic queue_refresh(input int sel);
    if (sel == 1) begin
      for (int i = 0; i < CAS_LEAD; i++) plan.push_back(mk(1, 0, 1, 0));
      for (int i = 0; i < T_RAS; i++)    plan.push_back(mk(0, 0, 1, 0));
    end else if (sel == 2) begin
      for (int b = 0; b < HID_BURST; b++) begin
        for (int i = 0; i < T_RP; i++)  plan.push_back(mk(1, 0, 1, 0));
        for (int i = 0; i < T_RAS; i++) plan.push_back(mk(0, 0, 1, 0));
      end
    end else begin
      for (int i = 0; i < T_RAS; i++) plan.push_back(mk(0, 1, 1, i == T_RAS - 1));
    end
    for (int i = 0; i < T_RP; i++) plan.push_back(mk(1, 1, 0, 0));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
    if (!rst_n) begin
      plan.delete(); m_cnt = 0; m_pend = 0; m_row = 0;
    end else begin
      bit go, due;
      go  = (plan.size() == 0) && m_pend && ref_gnt;
      due = (m_cnt == INTERVAL - 1);
      if (plan.size() != 0) begin
        slot_t s;
        s = plan.pop_front();
        if (s.inc) m_row = (m_row + 1) % (1 << ROW_W);
      end
      if (go) queue_refresh(int'(mode_sel));
      m_cnt  = due ? 0 : m_cnt + 1;
      m_pend = due || (m_pend && !go);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      slot_t e;
      e = (plan.size() != 0) ? plan[0] : mk(1, 1, 0, 0);
      check("R2 R3", "ref_req", int'(ref_req), int'(m_pend));
      check("R4 R5 R7", "ras_n", int'(ras_n), int'(e.ras));
      check("R6 R7 R10", "cas_n", int'(cas_n), int'(e.cas));
      check("R8", "busy", int'(busy), int'(e.bsy));
      check("R9", "row_addr", int'(row_addr), m_row);
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int wraps_seen;
    hold(3);
    check("R1", "ras_n in reset", int'(ras_n), 1);
    check("R1", "cas_n in reset", int'(cas_n), 1);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "ref_req in reset", int'(ref_req), 0);
    check("R1", "row_addr in reset", int'(row_addr), 0);
    rst_n = 1'b1;
    // R3: no grant across several intervals; the request saturates at one
    hold(3 * INTERVAL + 5);
    // R5: row-addressed refreshes
    mode_sel = 2'd0; ref_gnt = 1'b1; hold(4 * INTERVAL);
    // R6: column-first
    mode_sel = 2'd1; hold(4 * INTERVAL);
    // R7: hidden
    mode_sel = 2'd2; hold(4 * INTERVAL);
    // R5: select code 3
    mode_sel = 2'd3; hold(2 * INTERVAL);
    // R4 R10: random grants and a mode that changes every cycle
    for (int i = 0; i < 20 * INTERVAL; i++) begin
      mode_sel = 2'($urandom_range(0, 3));
      ref_gnt  = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    // R9: enough row-addressed refreshes for the counter to wrap
    mode_sel = 2'd0; ref_gnt = 1'b1;
    wraps_seen = 0;
    for (int i = 0; i < 262 * INTERVAL; i++) begin
      @(negedge clk);
      if (row_addr == '0 && busy == 1'b0 && i > INTERVAL) wraps_seen = 1;
    end
    check("R9", "row counter wrapped to zero", wraps_seen, 1);
    done = 1;
    summary();
    $finish;
  end
endmodule